// File: doc/BRIEF.md
# Multi-Slot PCM Voice Port

This block is a serial PCM audio port that carries five voice channels in one frame. Three synchronous voice links and a stereo pair (right, then left) each own a fixed 16-bit slot. Each slot carries a 13-bit narrowband sample. The placement of the sample inside the slot and its bit order are set by configuration. Transmit samples come in as one parallel word per slot. Received samples leave as sign-extended 16-bit words, each with a slot index and a one-cycle valid strobe.

The port runs either as timing master or as timing slave. As master, it derives the bit clock from the system clock through a programmable divider and generates the frame sync itself. As slave, it takes bit clock, sync and data from outside, resamples them into the system clock domain and acts on the detected edges. Data leaves on the rising bit-clock edge and is captured on the falling edge. A per-slot enable mask decides which slots are driven and received. The data-out line is released to high impedance whenever no enabled slot is being driven.

Top module: `pcm_voice_port`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `dout_oe`, `rx_valid`, `bclk_out` and `sync_out` are all 0.
- R2: In master mode, `bclk_out` toggles every `cfg_clk_div`+1 system clock cycles.
- R3: In master mode a frame lasts 80 bit periods, and sync is high in the last bit period of the previous frame (period 79). A short sync (`cfg_long_sync`=0) is high only then. A long sync (`cfg_long_sync`=1) stays high from that period through frame bit 14, 16 periods in all.
- R4: Frame bit n belongs to slot n/16, in this order: index 0, 1 and 2 are voice links 1 to 3, index 3 is stereo right and index 4 is stereo left. `tx_samples[s*13 +: 13]` feeds slot s. Each output bit changes with a rising bit-clock edge. The transmit words for a whole frame are captured at the rising edge that starts bit 0.
- R5: With offset o = `cfg_offset` (0 to 3), the sample occupies slot bit positions o to o+12, counted in transmission order. The three remaining bit positions of an enabled slot are driven as 0.
- R6: With `cfg_lsb_first`=0, sample bit 12 is sent and received first and sample bit 0 last. With `cfg_lsb_first`=1 the order is reversed.
- R7: `dout_oe` is high during every one of the 16 bits of an enabled slot inside a running frame, and low at all other times.
- R8: `din` is sampled on each falling bit-clock edge. After the falling edge of the last bit of an enabled slot, `rx_valid` pulses for one cycle. `rx_slot` then holds the slot index and `rx_sample` holds the 13 field bits, sign-extended from bit 12. The three bits outside the field have no effect on `rx_sample`.
- R9: A slot whose `cfg_slot_en` bit is 0 never produces `rx_valid`.
- R10: In slave mode (`cfg_master`=0), a frame starts at the first rising `bclk_in` edge after a falling edge on which `sync_in` is seen high after having been low. Without a new sync the frame ends after 80 bits, and `bclk_out` and `sync_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate bit clock and sync; 0: follow external ones |
| cfg_long_sync | input | 1 | Master sync shape: 0 short, 1 long |
| cfg_lsb_first | input | 1 | Sample bit order inside the field |
| cfg_offset | input | 2 | First slot bit position of the 13-bit field |
| cfg_clk_div | input | DIV_W | Master bit-clock half period minus one, in system clocks |
| cfg_slot_en | input | NUM_SLOTS | Per-slot enable mask, bit s for slot s |
| tx_samples | input | NUM_SLOTS*13 | Transmit samples, 13 bits per slot |
| bclk_in | input | 1 | External bit clock (slave) |
| sync_in | input | 1 | External frame sync (slave) |
| din | input | 1 | Serial receive data |
| bclk_out | output | 1 | Generated bit clock (master) |
| sync_out | output | 1 | Generated frame sync (master) |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Drive enable for `dout` |
| rx_sample | output | 16 | Received sample, sign-extended |
| rx_slot | output | $clog2(NUM_SLOTS) | Slot index of `rx_sample` |
| rx_valid | output | 1 | One-cycle strobe for a received sample |

## Verification
The assertions check, on every cycle, several rules that hold whatever the traffic is. The bit clock may only flip when the divider has run out. A short sync must drop at the next bit. The bit counter stays in range and moves only on a rising edge. The receive strobe is a single cycle, follows a falling edge and belongs to an enabled slot. A slave edge detector never fires twice in a row. The bench's scenarios show the behaviour that depends on data and mode. These are the slot order, where the 13-bit field sits and in which order its bits go out, sign extension that ignores the padding bits, frame-start capture of the transmit words while they change, and slave framing with both sync shapes. They also include the end of a frame when no sync follows.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int SLOT_W = 16;
    localparam int SAMP_W = 13;
    localparam int PAD_W  = SLOT_W - SAMP_W;
    localparam int SB_W   = $clog2(SLOT_W);
    localparam int OFF_W  = $clog2(PAD_W + 1);

    // bit-clock events as seen in the system clock domain
    typedef struct packed {
        logic rise;
        logic fall;
        logic sync;
    } bit_evt_t;

    // where a slot bit lands inside the 13-bit sample
    typedef struct packed {
        logic            hit;
        logic [SB_W-1:0] idx;
    } fld_map_t;

    function automatic fld_map_t locate(input logic [SB_W-1:0]  sb,
                                        input logic [OFF_W-1:0] off,
                                        input logic             lsb);
        fld_map_t m;
        int k;
        k = int'(sb) - int'(off);
        m.hit = (k >= 0) && (k < SAMP_W);
        if (!m.hit)
            m.idx = '0;
        else if (lsb)
            m.idx = SB_W'(k);
        else
            m.idx = SB_W'(SAMP_W - 1 - k);
        return m;
    endfunction

    function automatic logic [SLOT_W-1:0] widen(input logic [SAMP_W-1:0] s);
        return {{PAD_W{s[SAMP_W-1]}}, s};
    endfunction

endpackage

// File: rtl/pcm_master_clk.sv
module pcm_master_clk
    import pcm_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FRAME_BITS = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             long_sync,
    input  logic [DIV_W-1:0] half_div,
    output bit_evt_t         ev,
    output logic             bclk,
    output logic             sync
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] PRE    = CNT_W'(FRAME_BITS - 2);
    localparam logic [CNT_W-1:0] LONG_E = CNT_W'(SLOT_W - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             bclk_q;
    logic [CNT_W-1:0] mcnt;
    logic             tick;

    assign tick = en && (div_cnt == half_div);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
            bclk_q  <= 1'b0;
            mcnt    <= PRE;
        end else if (tick) begin
            div_cnt <= '0;
            bclk_q  <= ~bclk_q;
            if (!bclk_q)
                mcnt <= (mcnt == LAST) ? '0 : mcnt + 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign sync    = en && ((mcnt == LAST) || (long_sync && (mcnt < LONG_E)));
    assign bclk    = bclk_q;
    assign ev.rise = tick && !bclk_q;
    assign ev.fall = tick && bclk_q;
    assign ev.sync = sync;

    // R2
    div_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(bclk_q)) |-> $past(div_cnt == half_div));

    // R3
    short_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !long_sync && ev.rise && sync) |=> !sync);

endmodule

// File: rtl/pcm_slave_sync.sv
module pcm_slave_sync
    import pcm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_in,
    input  logic     sync_in,
    input  logic     din,
    output bit_evt_t ev,
    output logic     din_s
);
    logic [2:0] stage [STAGES];
    logic       bclk_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage[g] <= '0;
            else if (g == 0)
                stage[g] <= {bclk_in, sync_in, din};
            else
                stage[g] <= stage[(g == 0) ? 0 : g - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bclk_d <= 1'b0;
        else
            bclk_d <= stage[STAGES-1][2];
    end

    assign ev.rise = stage[STAGES-1][2] && !bclk_d;
    assign ev.fall = !stage[STAGES-1][2] && bclk_d;
    assign ev.sync = stage[STAGES-1][1];
    assign din_s   = stage[STAGES-1][0];

    // R10
    rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> !ev.rise);

endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
    import pcm_pkg::*;
#(
    parameter int NUM_SLOTS = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  bit_evt_t                     ev,
    input  logic                         din_bit,
    input  logic [OFF_W-1:0]             offset,
    input  logic                         lsb_first,
    input  logic [NUM_SLOTS-1:0]         slot_en,
    input  logic [NUM_SLOTS*SAMP_W-1:0]  tx_flat,
    output logic                         dout,
    output logic                         dout_oe,
    output logic [SLOT_W-1:0]            rx_sample,
    output logic [$clog2(NUM_SLOTS)-1:0] rx_slot,
    output logic                         rx_valid
);
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int SIDX_W     = $clog2(NUM_SLOTS);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [SB_W-1:0]  SB_LAST = SB_W'(SLOT_W - 1);

    logic              running;
    logic              pending;
    logic              sync_prev;
    logic [CNT_W-1:0]  bitcnt;
    logic [SAMP_W-1:0] tx_hold [NUM_SLOTS];
    logic [SAMP_W-1:0] rx_acc;
    logic [SAMP_W-1:0] acc_next;

    logic [SIDX_W-1:0] cur_slot;
    logic [SB_W-1:0]   sb;
    fld_map_t          fm;
    logic              en_sel;
    logic [SAMP_W-1:0] tx_word;
    logic              slot_on;

    assign cur_slot = SIDX_W'(bitcnt >> SB_W);
    assign sb       = bitcnt[SB_W-1:0];
    assign fm       = locate(sb, offset, lsb_first);

    always_comb begin
        en_sel  = 1'b0;
        tx_word = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (cur_slot == SIDX_W'(s)) begin
                en_sel  = slot_en[s];
                tx_word = tx_hold[s];
            end
        end
    end

    assign slot_on = running && en_sel;
    assign dout_oe = slot_on;
    assign dout    = slot_on && fm.hit && tx_word[fm.idx];

    always_comb begin
        acc_next = rx_acc;
        if (fm.hit)
            acc_next[fm.idx] = din_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            pending   <= 1'b0;
            sync_prev <= 1'b0;
            bitcnt    <= '0;
            rx_acc    <= '0;
            rx_valid  <= 1'b0;
            rx_slot   <= '0;
            rx_sample <= '0;
            for (int s = 0; s < NUM_SLOTS; s++)
                tx_hold[s] <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (ev.fall) begin
                sync_prev <= ev.sync;
                if (ev.sync && !sync_prev)
                    pending <= 1'b1;
                if (slot_on) begin
                    if (sb == SB_LAST) begin
                        rx_valid  <= 1'b1;
                        rx_slot   <= cur_slot;
                        rx_sample <= widen(acc_next);
                        rx_acc    <= '0;
                    end else begin
                        rx_acc <= acc_next;
                    end
                end
            end
            if (ev.rise) begin
                if (pending) begin
                    pending <= 1'b0;
                    running <= 1'b1;
                    bitcnt  <= '0;
                    rx_acc  <= '0;
                    for (int s = 0; s < NUM_SLOTS; s++)
                        tx_hold[s] <= tx_flat[s*SAMP_W +: SAMP_W];
                end else if (running) begin
                    if (bitcnt == LAST)
                        running <= 1'b0;
                    else
                        bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R8
    rxv_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    rxv_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(ev.fall));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (bitcnt <= LAST));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !ev.rise) |=> $stable(bitcnt));

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int DIV_W     = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_master,
    input  logic                         cfg_long_sync,
    input  logic                         cfg_lsb_first,
    input  logic [OFF_W-1:0]             cfg_offset,
    input  logic [DIV_W-1:0]             cfg_clk_div,
    input  logic [NUM_SLOTS-1:0]         cfg_slot_en,
    input  logic [NUM_SLOTS*SAMP_W-1:0]  tx_samples,
    input  logic                         bclk_in,
    input  logic                         sync_in,
    input  logic                         din,
    output logic                         bclk_out,
    output logic                         sync_out,
    output logic                         dout,
    output logic                         dout_oe,
    output logic [SLOT_W-1:0]            rx_sample,
    output logic [$clog2(NUM_SLOTS)-1:0] rx_slot,
    output logic                         rx_valid
);
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_W;

    bit_evt_t m_ev;
    bit_evt_t s_ev;
    bit_evt_t ev_sel;
    logic     s_din;
    logic     din_sel;

    pcm_master_clk #(
        .DIV_W      (DIV_W),
        .FRAME_BITS (FRAME_BITS)
    ) u_mclk (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_master),
        .long_sync (cfg_long_sync),
        .half_div  (cfg_clk_div),
        .ev        (m_ev),
        .bclk      (bclk_out),
        .sync      (sync_out)
    );

    pcm_slave_sync #(
        .STAGES (SYNC_STG)
    ) u_ssync (
        .clk     (clk),
        .rst     (rst),
        .bclk_in (bclk_in),
        .sync_in (sync_in),
        .din     (din),
        .ev      (s_ev),
        .din_s   (s_din)
    );

    assign ev_sel  = cfg_master ? m_ev : s_ev;
    assign din_sel = cfg_master ? din  : s_din;

    pcm_framer #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev_sel),
        .din_bit   (din_sel),
        .offset    (cfg_offset),
        .lsb_first (cfg_lsb_first),
        .slot_en   (cfg_slot_en),
        .tx_flat   (tx_samples),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .rx_sample (rx_sample),
        .rx_slot   (rx_slot),
        .rx_valid  (rx_valid)
    );

    // R9
    rx_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> cfg_slot_en[rx_slot]);

    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_master |-> (!bclk_out && !sync_out));

endmodule

// File: tb/sim_pcm_voice_port.sv
`timescale 1ns/1ps
module sim_pcm_voice_port;
    localparam int NS = 5;
    localparam int FB = 80;
    localparam int H  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b1, cfg_long_sync = 1'b0, cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_offset = 2'd0;
    logic [7:0]  cfg_clk_div = 8'd1;
    logic [4:0]  cfg_slot_en = 5'h1f;
    logic [64:0] tx_samples = '0;
    logic        bclk_in = 1'b0, sync_in = 1'b0, din = 1'b0;
    logic        bclk_out, sync_out, dout, dout_oe, rx_valid;
    logic [15:0] rx_sample;
    logic [2:0]  rx_slot;

    int total = 0, bad = 0;

    // behavioural model state
    bit          m_run, m_pend, m_sprev;
    int          m_pos;
    logic [12:0] m_tx [NS];
    logic [15:0] rx_pat [NS];
    int          q_slot [$];
    logic [15:0] q_val [$];

    always #5 clk = ~clk;

    pcm_voice_port u0 (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_long_sync(cfg_long_sync),
        .cfg_lsb_first(cfg_lsb_first), .cfg_offset(cfg_offset), .cfg_clk_div(cfg_clk_div),
        .cfg_slot_en(cfg_slot_en), .tx_samples(tx_samples), .bclk_in(bclk_in),
        .sync_in(sync_in), .din(din), .bclk_out(bclk_out), .sync_out(sync_out),
        .dout(dout), .dout_oe(dout_oe), .rx_sample(rx_sample), .rx_slot(rx_slot),
        .rx_valid(rx_valid));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int field_idx(input int b);
        int k;
        k = b - int'(cfg_offset);
        if (k < 0 || k > 12) return -1;
        return cfg_lsb_first ? k : 12 - k;
    endfunction

    function automatic logic exp_tx_bit(input int pos);
        int i;
        i = field_idx(pos % 16);
        if (i < 0) return 1'b0;
        return m_tx[pos / 16][i];
    endfunction

    function automatic logic [15:0] exp_rx(input int s);
        logic [12:0] v;
        v = '0;
        for (int b = 0; b < 16; b++) begin
            int i;
            i = field_idx(b);
            if (i >= 0) v[i] = rx_pat[s][b];
        end
        return {{3{v[12]}}, v};
    endfunction

    task automatic model_rise();
        if (m_pend) begin
            m_pend = 0; m_run = 1; m_pos = 0;
            for (int s = 0; s < NS; s++) m_tx[s] = tx_samples[s*13 +: 13];
        end else if (m_run) begin
            if (m_pos == FB - 1) m_run = 0;
            else m_pos++;
        end
    endtask

    task automatic model_fall(input logic s);
        if (m_run && cfg_slot_en[m_pos / 16] && (m_pos % 16 == 15)) begin
            q_slot.push_back(m_pos / 16);
            q_val.push_back(exp_rx(m_pos / 16));
        end
        if (s && !m_sprev) m_pend = 1;
        m_sprev = s;
    endtask

    task automatic check_out();
        bit eoe;
        eoe = m_run && cfg_slot_en[m_pos / 16];
        // R7 drive enable
        chk(dout_oe == eoe, "R7", "dout_oe", 32'(dout_oe), 32'(eoe));
        // R4 R5 R6 transmitted bit
        if (eoe) chk(dout == exp_tx_bit(m_pos), "R4 R5 R6", "dout", 32'(dout), 32'(exp_tx_bit(m_pos)));
    endtask

    task automatic monitor_rx();
        if (rx_valid) begin
            if (q_slot.size() == 0) begin
                // R9 no strobe without an enabled slot end
                chk(1'b0, "R9", "unexpected rx_valid slot", 32'(rx_slot), 32'hffff);
            end else begin
                int es;
                logic [15:0] ev;
                es = q_slot.pop_front();
                ev = q_val.pop_front();
                // R8 slot index and sign-extended sample
                chk(int'(rx_slot) == es, "R8", "rx_slot", 32'(rx_slot), 32'(es));
                chk(rx_sample == ev, "R8 R6", "rx_sample", 32'(rx_sample), 32'(ev));
            end
        end
    endtask

    task automatic setup(input bit mst, input bit lng, input bit lsb, input logic [1:0] off,
                         input logic [7:0] dv, input logic [4:0] en);
        rst = 1'b1;
        cfg_master = mst; cfg_long_sync = lng; cfg_lsb_first = lsb;
        cfg_offset = off; cfg_clk_div = dv; cfg_slot_en = en;
        bclk_in = 0; sync_in = 0; din = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dout_oe == 0, "R1", "dout_oe in reset", 32'(dout_oe), 0);
        chk(rx_valid == 0, "R1", "rx_valid in reset", 32'(rx_valid), 0);
        chk(bclk_out == 0 && sync_out == 0, "R1", "bclk/sync in reset", 32'({bclk_out, sync_out}), 0);
        m_run = 0; m_pend = 0; m_sprev = 0; m_pos = 0;
        q_slot.delete(); q_val.delete();
        for (int s = 0; s < NS; s++) begin
            rx_pat[s] = 16'($urandom);
            m_tx[s] = '0;
        end
        tx_samples = 65'({$urandom, $urandom, $urandom});
        rst = 1'b0;
    endtask

    task automatic run_master(input int n);
        logic pb;
        int hc;
        bit first;
        pb = bclk_out; hc = 0; first = 1;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            hc++;
            if (bclk_out !== pb) begin
                // R2 half period
                if (!first) chk(hc == int'(cfg_clk_div) + 1, "R2", "half period", 32'(hc), 32'(int'(cfg_clk_div) + 1));
                first = 0; hc = 0;
                if (bclk_out) begin
                    model_rise();
                    din = m_run ? rx_pat[m_pos / 16][m_pos % 16] : 1'b0;
                end else begin
                    if (m_run) begin
                        bit es;
                        es = cfg_long_sync ? (m_pos == FB - 1 || m_pos < 15) : (m_pos == FB - 1);
                        // R3 sync shape
                        chk(sync_out == es, "R3", "sync_out", 32'(sync_out), 32'(es));
                    end
                    model_fall(sync_out);
                end
                pb = bclk_out;
            end
            if (($urandom % 29) == 0) tx_samples = 65'({$urandom, $urandom, $urandom});
            check_out();
            monitor_rx();
        end
    endtask

    task automatic run_slave(input int nfr, input bit lng);
        for (int t = 0; t < FB * nfr + 3; t++) begin
            bclk_in = 1'b1;
            if (lng) sync_in = (t % FB < 16) && (t / FB < nfr);
            else     sync_in = (t % FB == 0) && (t / FB < nfr);
            model_rise();
            din = m_run ? rx_pat[m_pos / 16][m_pos % 16] : 1'($urandom);
            repeat (H) begin @(negedge clk); monitor_rx(); end
            check_out();
            // R10 no clock or sync generated as slave
            chk(bclk_out == 0 && sync_out == 0, "R10", "slave outputs", 32'({bclk_out, sync_out}), 0);
            bclk_in = 1'b0;
            model_fall(sync_in);
            repeat (H) begin @(negedge clk); monitor_rx(); end
            check_out();
        end
    endtask

    initial begin
        // master, short sync, MSB first, offset 0, all slots
        setup(1, 0, 0, 2'd0, 8'd1, 5'b11111);
        run_master(800);
        // master, long sync, LSB first, offset 3, slots 0/2/4 (R9 on the others)
        setup(1, 1, 1, 2'd3, 8'd2, 5'b10101);
        run_master(1200);
        // master, fastest divider, all slots off: line stays released (R7)
        setup(1, 0, 0, 2'd1, 8'd0, 5'b00000);
        run_master(500);
        // slave, short sync, LSB first, offset 2, two frames then stop (R10)
        setup(0, 0, 1, 2'd2, 8'd1, 5'b11011);
        run_slave(2, 0);
        // slave, long sync, MSB first, offset 0
        setup(0, 1, 0, 2'd0, 8'd1, 5'b11111);
        run_slave(1, 1);
        repeat (10) @(negedge clk);
        // R8 every expected strobe arrived
        chk(q_slot.size() == 0, "R8", "missing rx_valid count", 32'(q_slot.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule